// File: doc/BRIEF.md
# Two-Wire Command Register Slave with Deferred Commit

This block is a target on a two-wire serial bus (I2C style, 7-bit addressing) that exposes a bank of byte-wide command registers. A host selects a register by sending a register index byte after the write address, then a value byte. Index and value bytes may alternate any number of times inside one transfer. Written values land in a staging bank first. The command outputs that downstream logic consumes change only when a STOP condition appears on the bus, so a set of related settings takes effect in one clock cycle.

Reads use a stored index pointer. The host writes the index, issues a repeated START with the read address, and receives one byte, MSB first. Reads return the staged value, so a host can confirm what it wrote before it sends STOP. The pointer is kept across transfers, so a register can be polled by sending only START and the read address. The block takes already-synchronized clock and data line samples and drives an open-drain pull-down enable for the data line.

Top module: `i2c_cmd_regbank`

## Requirements
- R1: After reset the data line pull-down is off and every command output byte is 0x00.
- R2: With the default 7-bit address 0x34, an address byte of 0x68 (LSB 0 = write) or 0x69 (LSB 1 = read) is acknowledged, and the pull-down stays on through the whole high phase of the ninth clock.
- R3: A non-matching address byte is not acknowledged, and the block stays off the data line for all further bytes until the next START.
- R4: After a write address, bytes alternate index, value, index, value; every one of them is acknowledged, and several index/value pairs can be written within one START.
- R5: A value byte is taken into the staging entry of the current index at its acknowledge; command outputs do not change before a STOP.
- R6: On STOP every staging entry is copied to its command output, with register k on bits [8k+7:8k]; staged values survive a repeated START addressed to another device.
- R7: After an index write, a repeated START and the read address, the block shifts out the staged byte of that index MSB first, including values not yet committed.
- R8: The read index persists until a new index is written, so START plus read address returns the same register again; a host ACK after a read byte makes the block send that register again.
- R9: Index values of 14 or above are acknowledged for index and value bytes, written values are discarded, and reads of them return 0x00.
- R10: A host NACK after a read byte releases the data line and the block ignores clocks until the next START.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronized serial clock line sample |
| sda_i | input | 1 | Synchronized serial data line sample |
| sda_pull_o | output | 1 | 1 = pull the data line low |
| cmd_regs_o | output | NUM_REGS*8 | Committed command registers, register k at [8k+7:8k] |

## Verification
The bench builds the block with its defaults: address 0x34 and 14 registers. With those defaults the last implemented index (13) and the first unimplemented one (14 and beyond, here 20) are both reachable, so the discard and zero-read rules can be checked against a real register at the edge. The 0x34 address fixes the 0x68/0x69 byte values, and a foreign address of 0x20 exercises the ignore path and the repeated START to another device.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;

  localparam int BYTE_W = 8;
  localparam int BIT_CNT_W = 4;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK_WR,
    ST_AACK_RD,
    ST_SUB,
    ST_SACK,
    ST_WDATA,
    ST_DACK,
    ST_RDATA,
    ST_RACK,
    ST_IGNORE
  } i2c_st_e;

endpackage

// File: rtl/i2c_line_events.sv
module i2c_line_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o,
  output logic scl_fall_o
);

  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  always_comb begin
    start_o    = scl_q & scl_i & sda_q & ~sda_i;
    stop_o     = scl_q & scl_i & ~sda_q & sda_i;
    scl_rise_o = ~scl_q & scl_i;
    scl_fall_o = scl_q & ~scl_i;
  end

endmodule

// File: rtl/i2c_proto_fsm.sv
module i2c_proto_fsm
  import i2c_cmd_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h34,
  parameter int NUM_REGS = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              wr_en_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic [BYTE_W-1:0] ptr_o,
  output logic              commit_o,
  output logic              sda_pull_o
);

  localparam logic [BIT_CNT_W-1:0] FULL_CNT = BIT_CNT_W'(BYTE_W);

  i2c_st_e                state_q, state_d;
  logic [BIT_CNT_W-1:0]   bitcnt_q, bitcnt_d;
  logic [BYTE_W-1:0]      shreg_q, shreg_d;
  logic [BYTE_W-1:0]      ptr_q, ptr_d;
  logic                   pull_q, pull_d;
  logic                   mack_q, mack_d;
  logic                   byte_done, ptr_in_range, addr_match;

  always_comb begin
    byte_done    = (bitcnt_q == FULL_CNT);
    ptr_in_range = (ptr_q < BYTE_W'(NUM_REGS));
    addr_match   = (shreg_q[BYTE_W-1:1] == DEV_ADDR);
  end

  always_comb begin
    state_d  = state_q;
    bitcnt_d = bitcnt_q;
    shreg_d  = shreg_q;
    ptr_d    = ptr_q;
    pull_d   = pull_q;
    mack_d   = mack_q;
    wr_en_o  = 1'b0;
    if (stop_i) begin
      state_d  = ST_IDLE;
      pull_d   = 1'b0;
      bitcnt_d = '0;
    end else if (start_i) begin
      state_d  = ST_ADDR;
      pull_d   = 1'b0;
      bitcnt_d = '0;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_SUB, ST_WDATA: begin
          if (scl_rise_i && !byte_done) begin
            shreg_d  = {shreg_q[BYTE_W-2:0], sda_i};
            bitcnt_d = bitcnt_q + 1'b1;
          end else if (scl_fall_i && byte_done) begin
            bitcnt_d = '0;
            if (state_q == ST_ADDR) begin
              if (addr_match) begin
                pull_d  = 1'b1;
                state_d = shreg_q[0] ? ST_AACK_RD : ST_AACK_WR;
              end else begin
                state_d = ST_IGNORE;
              end
            end else if (state_q == ST_SUB) begin
              ptr_d   = shreg_q;
              pull_d  = 1'b1;
              state_d = ST_SACK;
            end else begin
              wr_en_o = ptr_in_range;
              pull_d  = 1'b1;
              state_d = ST_DACK;
            end
          end
        end
        ST_AACK_WR, ST_DACK: begin
          if (scl_fall_i) begin
            pull_d  = 1'b0;
            state_d = ST_SUB;
          end
        end
        ST_SACK: begin
          if (scl_fall_i) begin
            pull_d  = 1'b0;
            state_d = ST_WDATA;
          end
        end
        ST_AACK_RD: begin
          if (scl_fall_i) begin
            shreg_d  = rd_data_i;
            pull_d   = ~rd_data_i[BYTE_W-1];
            bitcnt_d = '0;
            state_d  = ST_RDATA;
          end
        end
        ST_RDATA: begin
          if (scl_rise_i && !byte_done) begin
            bitcnt_d = bitcnt_q + 1'b1;
          end else if (scl_fall_i) begin
            if (byte_done) begin
              pull_d   = 1'b0;
              bitcnt_d = '0;
              state_d  = ST_RACK;
            end else if (bitcnt_q != '0) begin
              shreg_d = {shreg_q[BYTE_W-2:0], 1'b0};
              pull_d  = ~shreg_q[BYTE_W-2];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise_i) begin
            mack_d = ~sda_i;
          end else if (scl_fall_i) begin
            if (mack_q) begin
              shreg_d  = rd_data_i;
              pull_d   = ~rd_data_i[BYTE_W-1];
              bitcnt_d = '0;
              state_d  = ST_RDATA;
            end else begin
              pull_d  = 1'b0;
              state_d = ST_IDLE;
            end
          end
        end
        default: begin
          pull_d = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      bitcnt_q <= '0;
      shreg_q  <= '0;
      ptr_q    <= '0;
      pull_q   <= 1'b0;
      mack_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      bitcnt_q <= bitcnt_d;
      shreg_q  <= shreg_d;
      ptr_q    <= ptr_d;
      pull_q   <= pull_d;
      mack_q   <= mack_d;
    end
  end

  assign wr_data_o  = shreg_q;
  assign ptr_o      = ptr_q;
  assign commit_o   = stop_i;
  assign sda_pull_o = pull_q;

  AST_PULL_ONLY_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_fall_i && !start_i && !stop_i) |=> $stable(pull_q)); // R2

  AST_IGNORE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IGNORE) |-> !pull_q); // R3

  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> !pull_q); // R10

endmodule

// File: rtl/i2c_stage_bank.sv
module i2c_stage_bank
  import i2c_cmd_pkg::*;
#(
  parameter int NUM_REGS = 14
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en_i,
  input  logic [BYTE_W-1:0]          wr_addr_i,
  input  logic [BYTE_W-1:0]          wr_data_i,
  input  logic                       commit_i,
  input  logic [BYTE_W-1:0]          rd_addr_i,
  output logic [BYTE_W-1:0]          rd_data_o,
  output logic [NUM_REGS*BYTE_W-1:0] live_o
);

  logic [NUM_REGS-1:0][BYTE_W-1:0] hold_q;
  logic [NUM_REGS-1:0][BYTE_W-1:0] live_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else begin
      for (int i = 0; i < NUM_REGS; i++) begin
        if (wr_en_i && (wr_addr_i == BYTE_W'(i))) begin
          hold_q[i] <= wr_data_i;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= '0;
    end else if (commit_i) begin
      live_q <= hold_q;
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rd_addr_i == BYTE_W'(i)) begin
        rd_data_o = hold_q[i];
      end
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_out
    assign live_o[g*BYTE_W +: BYTE_W] = live_q[g];
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> $stable(hold_q)); // R5

  AST_LIVE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_i |=> $stable(live_q)); // R6

  AST_WR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |-> (wr_addr_i < BYTE_W'(NUM_REGS))); // R9

endmodule

// File: rtl/i2c_cmd_regbank.sv
module i2c_cmd_regbank
  import i2c_cmd_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h34,
  parameter int NUM_REGS = 14
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       scl_i,
  input  logic                       sda_i,
  output logic                       sda_pull_o,
  output logic [NUM_REGS*BYTE_W-1:0] cmd_regs_o
);

  logic [1:0]        rst_sync_q;
  logic              rst_n_int;
  logic              start_w, stop_w, rise_w, fall_w;
  logic              wr_en_w, commit_w;
  logic [BYTE_W-1:0] wr_data_w, ptr_w, rd_data_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  i2c_line_events u_events (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .start_o    (start_w),
    .stop_o     (stop_w),
    .scl_rise_o (rise_w),
    .scl_fall_o (fall_w)
  );

  i2c_proto_fsm #(.DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .sda_i      (sda_i),
    .start_i    (start_w),
    .stop_i     (stop_w),
    .scl_rise_i (rise_w),
    .scl_fall_i (fall_w),
    .rd_data_i  (rd_data_w),
    .wr_en_o    (wr_en_w),
    .wr_data_o  (wr_data_w),
    .ptr_o      (ptr_w),
    .commit_o   (commit_w),
    .sda_pull_o (sda_pull_o)
  );

  i2c_stage_bank #(.NUM_REGS(NUM_REGS)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .wr_en_i   (wr_en_w),
    .wr_addr_i (ptr_w),
    .wr_data_i (wr_data_w),
    .commit_i  (commit_w),
    .rd_addr_i (ptr_w),
    .rd_data_o (rd_data_w),
    .live_o    (cmd_regs_o)
  );

endmodule

// File: tb/i2c_cmd_regbank_tb.sv
module i2c_cmd_regbank_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int Q = 4;
  localparam int NR = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_pull;
  logic [NR*8-1:0] cmd_o;
  logic sda_line;
  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] exp_hold [NR];
  logic [7:0] exp_live [NR];

  assign sda_line = sda_m & ~sda_pull;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_cmd_regbank dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_m),
    .sda_i      (sda_line),
    .sda_pull_o (sda_pull),
    .cmd_regs_o (cmd_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string req);
    logic a1, a2;
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0;
    end
    sda_m = 1'b1; wq(); scl_m = 1'b1; #1; a1 = ~sda_line;
    wq(); wq(); a2 = ~sda_line; scl_m = 1'b0;
    chk(req, {30'd0, a1, a2}, {30'd0, exp_ack, exp_ack});
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] d);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(); scl_m = 1'b1; wq(); d[i] = sda_line; wq(); scl_m = 1'b0;
    end
    sda_m = ~mack; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; #1; sda_m = 1'b1;
  endtask

  task automatic chk_live(input string req);
    for (int k = 0; k < NR; k++) chk(req, {24'd0, cmd_o[k*8 +: 8]}, {24'd0, exp_live[k]});
  endtask

  task automatic commit_model();
    for (int k = 0; k < NR; k++) exp_live[k] = exp_hold[k];
  endtask

  task automatic t_reset();
    chk("R1 pull", {31'd0, sda_pull}, 32'd0);
    chk_live("R1 outputs");
  endtask

  task automatic t_stage_commit();
    logic [7:0] d;
    bus_start();
    send_byte(8'h68, 1'b1, "R2 write addr ack");
    send_byte(8'h00, 1'b1, "R4 index ack");
    send_byte(8'hA5, 1'b1, "R4 value ack");
    exp_hold[0] = 8'hA5;
    send_byte(8'h0D, 1'b1, "R4 second index ack");
    send_byte(8'h3C, 1'b1, "R4 second value ack");
    exp_hold[13] = 8'h3C;
    chk_live("R5 no change before stop");
    bus_start();
    send_byte(8'h68, 1'b1, "R2 write addr ack");
    send_byte(8'h00, 1'b1, "R4 index ack");
    bus_start();
    send_byte(8'h69, 1'b1, "R2 read addr ack");
    recv_byte(1'b0, d);
    chk("R7 staged readback", {24'd0, d}, 32'hA5);
    chk("R10 released after nack", {31'd0, sda_pull}, 32'd0);
    chk_live("R5 still uncommitted");
    bus_stop();
    commit_model();
    chk_live("R6 commit on stop");
  endtask

  task automatic t_mismatch();
    bus_start();
    send_byte(8'h40, 1'b0, "R3 foreign addr nack");
    send_byte(8'h68, 1'b0, "R3 ignored until start");
    send_byte(8'h00, 1'b0, "R3 ignored until start");
    bus_stop();
    chk_live("R3 outputs kept");
  endtask

  task automatic t_rep_start_other();
    bus_start();
    send_byte(8'h68, 1'b1, "R2 write addr ack");
    send_byte(8'h02, 1'b1, "R4 index ack");
    send_byte(8'h77, 1'b1, "R4 value ack");
    exp_hold[2] = 8'h77;
    bus_start();
    send_byte(8'h40, 1'b0, "R3 other device");
    send_byte(8'h55, 1'b0, "R3 other device data");
    chk_live("R5 no change before stop");
    bus_stop();
    commit_model();
    chk_live("R6 staged kept over other device");
  endtask

  task automatic t_poll();
    logic [7:0] d;
    bus_start();
    send_byte(8'h69, 1'b1, "R8 read addr ack");
    recv_byte(1'b1, d);
    chk("R8 poll first", {24'd0, d}, 32'h77);
    recv_byte(1'b0, d);
    chk("R8 after host ack", {24'd0, d}, 32'h77);
    bus_start();
    send_byte(8'h69, 1'b1, "R8 read addr ack");
    recv_byte(1'b0, d);
    chk("R8 poll again", {24'd0, d}, 32'h77);
    recv_byte(1'b0, d);
    chk("R10 silent after nack", {24'd0, d}, 32'hFF);
    bus_stop();
  endtask

  task automatic t_out_of_range();
    logic [7:0] d;
    bus_start();
    send_byte(8'h68, 1'b1, "R2 write addr ack");
    send_byte(8'd20, 1'b1, "R9 index ack");
    send_byte(8'hFF, 1'b1, "R9 value ack");
    bus_stop();
    chk_live("R9 discarded");
    bus_start();
    send_byte(8'h68, 1'b1, "R2 write addr ack");
    send_byte(8'd20, 1'b1, "R9 index ack");
    bus_start();
    send_byte(8'h69, 1'b1, "R2 read addr ack");
    recv_byte(1'b0, d);
    chk("R9 reads zero", {24'd0, d}, 32'h00);
    bus_start();
    send_byte(8'h68, 1'b1, "R2 write addr ack");
    send_byte(8'h0D, 1'b1, "R4 index ack");
    bus_start();
    send_byte(8'h69, 1'b1, "R2 read addr ack");
    recv_byte(1'b0, d);
    chk("R7 last register", {24'd0, d}, 32'h3C);
    bus_stop();
  endtask

  initial begin
    for (int k = 0; k < NR; k++) begin
      exp_hold[k] = 8'h00;
      exp_live[k] = 8'h00;
    end
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    t_reset();
    t_stage_commit();
    t_mismatch();
    t_rep_start_other();
    t_poll();
    t_out_of_range();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule